// File: doc/BRIEF.md
# Break-Protected Two-Step Status Flags

This block holds a peripheral's status register. Hardware events set the flags. Software clears a flag in two steps:

1. It reads the status register while the flag is 1. This arms that flag.
2. Later, it accesses the associated data register. This clears every armed flag.

Each flag has its own arm bit. A new hardware set on a flag discards its arm, so software must run both steps again.

A debug-break level and a break-clear-enable bit decide whether software accesses made during a break count. The enable bit resets to 0. With the enable at 0, a break freezes the flags and their arm bits against software. A debugger can then read and write registers without disturbing the flags. A clear that was half done before the break is kept, and the second step completes it after the break. With the enable at 1, accesses made during a break clear flags as usual, and a flag cleared this way stays cleared after the break ends.

Top module: `brk_status_flags`

## Requirements
- R1: Synchronous reset (`rst`=1 at a clock edge) clears all 8 flags and all arm bits; `flags_o` reads 0 in the cycle after reset.
- R2: A pulse on `set_evt_i[i]` makes `flags_o[i]` 1 from the following clock edge; other bits are unaffected.
- R3: Outside a break, a `stat_rd_i` cycle arms every flag that is 1 in that cycle; a later `data_acc_i` cycle clears all armed flags at the next edge, and flags that were not armed keep their value.
- R4: A `data_acc_i` cycle has no effect on a flag whose arm bit is not set.
- R5: A set event on a flag clears its arm bit, so a following data access alone does not clear that flag; a fresh read must arm it again.
- R6: When a set event and a valid second step hit the same flag in the same cycle, the flag stays 1 (set wins).
- R7: While `brk_i`=1 and `brk_clr_en_i`=0, a status read arms no flag and a data access clears no flag. This holds even if an access made during the break would otherwise complete a clear.
- R8: An arm set before a protected break is kept through the break; one data access after the break clears that flag.
- R9: While `brk_i`=1 and `brk_clr_en_i`=1, the two-step sequence clears flags normally, and a flag cleared this way stays 0 after `brk_i` falls.
- R10: A data access that clears a flag also drops its arm bit. If a read and a data access fall in the same cycle, only arms that existed before that cycle are consumed. The read arms the flags that remain set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_evt_i | input | 8 | Per-flag hardware set pulses |
| stat_rd_i | input | 1 | Status register read strobe (step one) |
| data_acc_i | input | 1 | Data register access strobe (step two) |
| brk_i | input | 1 | Debug break active level |
| brk_clr_en_i | input | 1 | Allow software clearing during a break |
| flags_o | output | 8 | Status flags |

## Verification
Every flag result is due one clock edge after the cycle that carries its stimulus. The flags and arm bits are the only registers between the strobes and `flags_o`. The bench drives inputs on the falling edge and updates its own model in the same step. It compares `flags_o` at the next falling edge, after exactly one rising edge. Arm state is never read directly. Each directed arm-related case makes the arm visible through the flag value that a later data access leaves behind.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  // next flag value: set dominates clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  // next arm value: set or completed clear drop it, qualified read raises it
  function automatic logic arm_next(input logic cur, input logic set, input logic clr,
                                    input logic arm_req);
    if (set || clr) return 1'b0;
    if (arm_req)    return 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/bsf_access_gate.sv
module bsf_access_gate #(
  parameter int unsigned N = 8
) (
  input  logic         stat_rd,
  input  logic         data_acc,
  input  logic         brk,
  input  logic         brk_clr_en,
  input  logic [N-1:0] flag_q,
  input  logic [N-1:0] arm_q,
  output logic [N-1:0] arm_req,
  output logic [N-1:0] clr_req
);
  logic acc_ok;

  // software accesses count outside a break, or in a break when allowed
  assign acc_ok  = !brk || brk_clr_en;
  assign arm_req = (stat_rd && acc_ok) ? flag_q : '0;
  assign clr_req = (data_acc && acc_ok) ? arm_q : '0;
endmodule

// File: rtl/bsf_flag_cell.sv
module bsf_flag_cell
  import bsf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic arm_req,
  input  logic clr_req,
  input  logic brk,
  input  logic brk_clr_en,
  output logic flag_q,
  output logic arm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, set_evt, clr_req);
      arm_q  <= arm_next(arm_q, set_evt, clr_req, arm_req);
    end
  end

  // R2
  set_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag_q);
  // R4
  unarmed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !arm_q) |=> flag_q);
  // R5
  set_drops_arm_chk: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> !arm_q);
  // R7
  protected_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (brk && !brk_clr_en && flag_q) |=> flag_q);
  // R8
  protected_arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (brk && !brk_clr_en && arm_q && !set_evt) |=> arm_q);
  // R7
  protected_no_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (brk && !brk_clr_en && !arm_q) |=> !arm_q);
  // R3
  arm_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    arm_q |-> flag_q);
endmodule

// File: rtl/brk_status_flags.sv
module brk_status_flags #(
  parameter int unsigned N_FLAGS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_FLAGS-1:0] set_evt_i,
  input  logic               stat_rd_i,
  input  logic               data_acc_i,
  input  logic               brk_i,
  input  logic               brk_clr_en_i,
  output logic [N_FLAGS-1:0] flags_o
);
  logic [N_FLAGS-1:0] flag_q;
  logic [N_FLAGS-1:0] arm_q;
  logic [N_FLAGS-1:0] arm_req;
  logic [N_FLAGS-1:0] clr_req;

  bsf_access_gate #(.N(N_FLAGS)) u_gate (
    .stat_rd    (stat_rd_i),
    .data_acc   (data_acc_i),
    .brk        (brk_i),
    .brk_clr_en (brk_clr_en_i),
    .flag_q     (flag_q),
    .arm_q      (arm_q),
    .arm_req    (arm_req),
    .clr_req    (clr_req)
  );

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_cell
    bsf_flag_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .set_evt    (set_evt_i[g]),
      .arm_req    (arm_req[g]),
      .clr_req    (clr_req[g]),
      .brk        (brk_i),
      .brk_clr_en (brk_clr_en_i),
      .flag_q     (flag_q[g]),
      .arm_q      (arm_q[g])
    );
  end

  assign flags_o = flag_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((set_evt_i & clr_req) != '0) |=> ((flags_o & $past(set_evt_i & clr_req)) == $past(set_evt_i & clr_req)));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags_o == '0));
endmodule

// File: tb/brk_status_flags_tb.sv
module brk_status_flags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [NF-1:0] set_evt;
  logic          stat_rd, data_acc, brk, brk_en;
  logic [NF-1:0] flags;

  int n_tests = 0;
  int n_fail  = 0;
  bit [NF-1:0] m_flag, m_arm;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_status_flags #(.N_FLAGS(NF)) u_dut (
    .clk(clk), .rst(rst), .set_evt_i(set_evt), .stat_rd_i(stat_rd),
    .data_acc_i(data_acc), .brk_i(brk), .brk_clr_en_i(brk_en), .flags_o(flags)
  );

  // bench model: one cycle of the requirements, written bit by bit
  function automatic void model_step(bit [NF-1:0] s, bit rd, bit da, bit b, bit en);
    bit counts;
    bit [NF-1:0] nf, na;
    counts = (b == 1'b0) || en;
    for (int i = 0; i < NF; i++) begin
      nf[i] = m_flag[i];
      na[i] = m_arm[i];
      if (counts && rd && m_flag[i]) na[i] = 1'b1;
      if (counts && da && m_arm[i]) begin nf[i] = 1'b0; na[i] = 1'b0; end
      if (s[i]) begin nf[i] = 1'b1; na[i] = 1'b0; end
    end
    m_flag = nf;
    m_arm  = na;
  endfunction

  task automatic check(string tag);
    n_tests++;
    if (flags !== m_flag) begin
      n_fail++;
      $display("FAIL %s: flags=%b expected=%b at %0t", tag, flags, m_flag, $time);
    end
  endtask

  // called at a falling edge: drive, step model, wait one edge, compare
  task automatic step(bit [NF-1:0] s, bit rd, bit da, bit b, bit en, string tag);
    set_evt = s; stat_rd = rd; data_acc = da; brk = b; brk_en = en;
    model_step(s, rd, da, b, en);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(int n, bit b, bit en, string tag);
    for (int k = 0; k < n; k++) step('0, 0, 0, b, en, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    rst = 1; set_evt = '0; stat_rd = 0; data_acc = 0; brk = 0; brk_en = 0;
    @(negedge clk); @(negedge clk);
    m_flag = '0; m_arm = '0;
    check("R1 reset");
    rst = 0;

    // R2 independent sets
    step(8'h05, 0, 0, 0, 0, "R2 set bits 0,2");
    step(8'h80, 0, 0, 0, 0, "R2 set bit 7");
    // R4 data access with nothing armed
    step('0, 0, 1, 0, 0, "R4 unarmed access");
    // R3 arm then clear; bit 4 set after read is untouched
    step('0, 1, 0, 0, 0, "R3 arm read");
    step(8'h10, 0, 0, 0, 0, "R3 set after read");
    step('0, 0, 1, 0, 0, "R3 clear armed only");
    // R5 set drops arm
    step('0, 1, 0, 0, 0, "R5 arm bit4");
    step(8'h10, 0, 0, 0, 0, "R5 re-set bit4");
    step('0, 0, 1, 0, 0, "R5 access after re-set");
    // R6 set wins over clear
    step('0, 1, 0, 0, 0, "R6 arm");
    step(8'h10, 0, 1, 0, 0, "R6 set with clear");
    // R7 protected break
    step(8'h21, 0, 0, 1, 0, "R7 set in break");
    step('0, 1, 0, 1, 0, "R7 read in break");
    step('0, 0, 1, 1, 0, "R7 access in break");
    step('0, 0, 1, 0, 0, "R7 access after break, no arm");
    // R8 arm kept across protected break
    step('0, 1, 0, 0, 0, "R8 arm before break");
    idle(3, 1, 0, "R8 break idle");
    step('0, 0, 1, 1, 0, "R8 access in break");
    step('0, 0, 1, 0, 0, "R8 second step after break");
    // R9 enabled break clearing
    step(8'h42, 0, 0, 0, 0, "R9 set");
    step('0, 1, 0, 1, 1, "R9 read in break");
    step('0, 0, 1, 1, 1, "R9 clear in break");
    idle(2, 0, 0, "R9 stays clear after break");
    // R10 read and access in the same cycle
    step(8'h03, 0, 0, 0, 0, "R10 set");
    step('0, 1, 0, 0, 0, "R10 arm 0,1");
    step(8'h0c, 0, 0, 0, 0, "R10 set 2,3");
    step('0, 1, 1, 0, 0, "R10 read+access");
    step('0, 0, 1, 0, 0, "R10 finish new arms");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      bit [NF-1:0] s;
      bit b, en;
      s = (($urandom % 4) == 0) ? NF'($urandom) & NF'($urandom) : '0;
      b  = (($urandom % 3) == 0);
      en = (($urandom % 2) == 0);
      step(s, ($urandom % 3) == 0, ($urandom % 3) == 0, b, en, "R3/R7/R9 random");
    end

    // R1 reset mid-run
    rst = 1; set_evt = '0; stat_rd = 0; data_acc = 0; brk = 0; brk_en = 0;
    @(negedge clk);
    m_flag = '0; m_arm = '0;
    check("R1 reset mid-run");
    rst = 0;
    step(8'hff, 0, 0, 0, 0, "R1 set after reset");
    step('0, 0, 1, 0, 0, "R1 arms cleared by reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule